// File: doc/BRIEF.md
# Programmable memory clock generator

This block derives a slow clock for an embedded non-volatile memory from the bus clock. Software writes a 6-bit period value through a simple write port. The generated clock then repeats every (value + 1) bus-clock cycles. Zero is not a legal divide. A written zero is stored as the default value 15, so it never divides by one.

Each period starts with the output low, followed by a high phase at its end. The length of the high phase is the integer half of the period. A newly written value waits until the current period has finished, so a period is never cut short. A one-cycle strobe marks the first bus cycle of every high phase. Logic that runs on the bus clock can use the strobe as a clock-enable in step with the memory clock.

Top module: `nvm_clkgen`

## Requirements
- R1: While reset is held and in the first cycle after it, the output and the strobe are low, the counter sits at the start of a period, and the stored period value is 15, giving a 16-cycle first period.
- R2: For a stored value v from 1 to 63, the output period is exactly v + 1 bus-clock cycles.
- R3: Writing 0 gives exactly the periods of writing 15: 16 cycles, with 8 high.
- R4: Each period is low first and then high for floor((v + 1) / 2) cycles, ending high; for an odd period the low phase is the longer one.
- R5: A write made during a period leaves that period's length and duty unchanged; the new value governs from the next period onward.
- R6: The strobe is high for exactly one bus cycle per period, in the first cycle in which the output is high, and at no other time.
- R7: When several writes fall within one period, the last one before the period ends is the value used for the next period.
- R8: With a value of 11 the period is 12 cycles, with 6 cycles high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Period value write enable |
| cfg_val | input | 6 | Period value to store (0 selects the default) |
| nvm_clk_o | output | 1 | Generated memory clock, registered |
| nvm_rise_o | output | 1 | One-cycle strobe in the first high cycle of each period |

## Verification
The bench builds the block with its default parameters: a 6-bit value field and a default of 15. This puts both ends of the legal range, 1 and 63, within a short run. Odd and even period lengths are both covered, along with a zero write that must collapse to the default. Every value change is written mid-period, so each comparison also confirms that the period in flight was unaffected.

// File: rtl/nvm_clkgen_pkg.sv
// Package: shared defaults for the memory clock generator.
// Assumes: the default value fits in the value field width.
package nvm_clkgen_pkg;
    localparam int unsigned NCLK_VAL_W    = 6;
    localparam int unsigned NCLK_DFLT_VAL = 15;
endpackage

// File: rtl/nclk_cfg_reg.sv
// Module: period value register.
// Holds the most recent written value and replaces a zero write by the default.
// Assumes: DFLT_VAL is nonzero and fits in VAL_W bits.
module nclk_cfg_reg #(
    parameter int unsigned VAL_W    = 6,
    parameter int unsigned DFLT_VAL = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [VAL_W-1:0] wval,
    output logic [VAL_W-1:0] pend_q
);
    localparam logic [VAL_W-1:0] DFLT = VAL_W'(DFLT_VAL);

    // Store the written value, mapping the illegal zero to the default.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_q <= DFLT;
        else if (we)
            pend_q <= (wval == '0) ? DFLT : wval;
    end
endmodule

// File: rtl/nclk_phase_ctr.sv
// Module: period counter.
// Counts 0..act_q and loads the pending value into act_q only at the period end.
// Assumes: pend never holds zero (the register maps it away).
module nclk_phase_ctr #(
    parameter int unsigned VAL_W    = 6,
    parameter int unsigned DFLT_VAL = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VAL_W-1:0] pend,
    output logic [VAL_W-1:0] cnt_q,
    output logic [VAL_W-1:0] act_q,
    output logic [VAL_W-1:0] cnt_nx,
    output logic [VAL_W-1:0] act_nx
);
    localparam logic [VAL_W-1:0] DFLT = VAL_W'(DFLT_VAL);

    logic at_end;

    // Next-state logic: wrap at the active limit and pick up the pending value there.
    always_comb begin
        at_end = (cnt_q == act_q);
        cnt_nx = at_end ? '0 : cnt_q + 1'b1;
        act_nx = at_end ? pend : act_q;
    end

    // State registers: start of a default-length period after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            act_q <= DFLT;
        end else begin
            cnt_q <= cnt_nx;
            act_q <= act_nx;
        end
    end
endmodule

// File: rtl/nclk_wave_out.sv
// Module: output waveform and rise strobe.
// Output is low for ceil((act+1)/2) counts, then high; both outputs registered.
// Assumes: cnt_nx and act_nx are the counter's next state.
module nclk_wave_out #(
    parameter int unsigned VAL_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VAL_W-1:0] cnt_nx,
    input  logic [VAL_W-1:0] act_nx,
    output logic             clk_q,
    output logic             stb_q
);
    logic [VAL_W:0] plen;
    logic [VAL_W:0] low_len;
    logic           out_nx;

    // Decode the level of the next cycle from the next count and limit.
    always_comb begin
        plen    = {1'b0, act_nx} + 1'b1;
        low_len = plen - (plen >> 1);
        out_nx  = ({1'b0, cnt_nx} >= low_len);
    end

    // Register the level and flag its low-to-high transition.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_q <= 1'b0;
            stb_q <= 1'b0;
        end else begin
            clk_q <= out_nx;
            stb_q <= out_nx & ~clk_q;
        end
    end
endmodule

// File: rtl/nvm_clkgen.sv
// Module: programmable memory clock generator (top).
// Divides the bus clock by (value + 1); zero selects DFLT_VAL; changes apply at period end.
// Assumes: single bus clock domain, synchronous active-low reset.
module nvm_clkgen #(
    parameter int unsigned VAL_W    = nvm_clkgen_pkg::NCLK_VAL_W,
    parameter int unsigned DFLT_VAL = nvm_clkgen_pkg::NCLK_DFLT_VAL
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [VAL_W-1:0] cfg_val,
    output logic             nvm_clk_o,
    output logic             nvm_rise_o
);
    logic [VAL_W-1:0] pend;
    logic [VAL_W-1:0] cnt_q;
    logic [VAL_W-1:0] act_q;
    logic [VAL_W-1:0] cnt_nx;
    logic [VAL_W-1:0] act_nx;

    nclk_cfg_reg #(.VAL_W(VAL_W), .DFLT_VAL(DFLT_VAL)) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (cfg_we),
        .wval   (cfg_val),
        .pend_q (pend)
    );

    nclk_phase_ctr #(.VAL_W(VAL_W), .DFLT_VAL(DFLT_VAL)) u_ctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .pend   (pend),
        .cnt_q  (cnt_q),
        .act_q  (act_q),
        .cnt_nx (cnt_nx),
        .act_nx (act_nx)
    );

    nclk_wave_out #(.VAL_W(VAL_W)) u_wave (
        .clk    (clk),
        .rst_n  (rst_n),
        .cnt_nx (cnt_nx),
        .act_nx (act_nx),
        .clk_q  (nvm_clk_o),
        .stb_q  (nvm_rise_o)
    );
endmodule

// File: rtl/nvm_clkgen_chk.sv
// Module: assertion checker for nvm_clkgen, attached by bind.
// Assumes: reset is asserted from time zero.
module nvm_clkgen_chk #(
    parameter int unsigned VAL_W    = 6,
    parameter int unsigned DFLT_VAL = 15
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clk_o,
    input logic             stb_o,
    input logic [VAL_W-1:0] cnt,
    input logic [VAL_W-1:0] act
);
    logic in_rst_q;

    // Remember whether the previous cycle was in reset.
    always_ff @(posedge clk) in_rst_q <= !rst_n;

    a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
        in_rst_q |-> (cnt == '0 && act == VAL_W'(DFLT_VAL) && !clk_o && !stb_o));

    a_r2_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= act);

    a_r3_limit_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        act != '0);

    a_r4_start_low: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0) |-> !clk_o);

    a_r4_end_high: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == act) |-> clk_o);

    a_r5_limit_held: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != act) |=> $stable(act));

    a_r6_stb_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        stb_o |-> (clk_o && !$past(clk_o)));

    a_r6_rise_has_stb: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_o) |-> stb_o);
endmodule

bind nvm_clkgen nvm_clkgen_chk #(.VAL_W(VAL_W), .DFLT_VAL(DFLT_VAL)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .clk_o (nvm_clk_o),
    .stb_o (nvm_rise_o),
    .cnt   (cnt_q),
    .act   (act_q)
);

// File: tb/nvm_clkgen_test.sv
// Bench: scoreboard. The driver pushes expected periods; the monitor measures
// each period (falling edge to falling edge) and compares.
module nvm_clkgen_test;
    localparam int VW = 6;

    typedef struct {
        int    len;
        int    hi;
        string tag;
    } per_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [VW-1:0] cfg_val = '0;
    logic          nvm_clk_o;
    logic          nvm_rise_o;

    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 1'b0;
    per_t exp_q[$];
    event period_start;

    nvm_clkgen uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_val    (cfg_val),
        .nvm_clk_o  (nvm_clk_o),
        .nvm_rise_o (nvm_rise_o)
    );

    always #5 clk = ~clk;

    function automatic per_t mk(int v, string tag);
        per_t p;
        int   e;
        e     = (v == 0) ? 15 : v;
        p.len = e + 1;
        p.hi  = (e + 1) / 2;
        p.tag = tag;
        return p;
    endfunction

    // Write v now (caller is at a period start), expect n periods of it.
    task automatic step(int v, int n, string tag);
        cfg_we  = 1'b1;
        cfg_val = VW'(v);
        @(negedge clk);
        cfg_we  = 1'b0;
        for (int i = 0; i < n; i++) exp_q.push_back(mk(v, tag));
        repeat (n) @(period_start);
    endtask

    // Two writes in one period; the second must win (R7).
    task automatic step2(int v1, int v2, int n);
        cfg_we  = 1'b1;
        cfg_val = VW'(v1);
        @(negedge clk);
        cfg_val = VW'(v2);
        @(negedge clk);
        cfg_we  = 1'b0;
        for (int i = 0; i < n; i++) exp_q.push_back(mk(v2, "R7 last write wins"));
        repeat (n) @(period_start);
    endtask

    // Monitor: measure periods and check the strobe at each negedge.
    bit started = 1'b0;
    bit prev_o  = 1'b0;
    int len_c   = 0;
    int hi_c    = 0;
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (!started) begin
                started = 1'b1;
                len_c = 1;
                hi_c  = 0;
            end else if (!nvm_clk_o && prev_o) begin
                per_t e;
                n_chk++;
                if (exp_q.size() == 0) begin
                    n_fail++;
                    $display("FAIL R2 unexpected period: actual len=%0d hi=%0d expected none",
                             len_c, hi_c);
                end else begin
                    e = exp_q.pop_front();
                    if (len_c != e.len || hi_c != e.hi) begin
                        n_fail++;
                        $display("FAIL %s (R2 R4 R5): actual len=%0d hi=%0d expected len=%0d hi=%0d",
                                 e.tag, len_c, hi_c, e.len, e.hi);
                    end
                end
                len_c = 1;
                hi_c  = 0;
                -> period_start;
            end else begin
                len_c++;
                if (nvm_clk_o) hi_c++;
            end
            if (nvm_clk_o && !prev_o) begin
                n_chk++;
                if (nvm_rise_o !== 1'b1) begin
                    n_fail++;
                    $display("FAIL R6 strobe at rise: actual %b expected 1", nvm_rise_o);
                end
            end else if (nvm_rise_o !== 1'b0) begin
                n_chk++;
                n_fail++;
                $display("FAIL R6 stray strobe: actual %b expected 0", nvm_rise_o);
            end
            prev_o = nvm_clk_o;
        end
    end

    task automatic finish_run();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (50000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        n_chk++;
        if (nvm_clk_o !== 1'b0 || nvm_rise_o !== 1'b0) begin
            n_fail++;
            $display("FAIL R1 reset outputs: actual %b%b expected 00", nvm_clk_o, nvm_rise_o);
        end
        exp_q.push_back(mk(15, "R1 default first period"));
        @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        step(11, 3, "R8 value 11");
        step(0, 2, "R3 zero as 15");
        step(1, 3, "R2 minimum value");
        step(63, 2, "R2 maximum value");
        step(2, 3, "R4 odd period");
        step(32, 1, "R5 change mid-period");
        step2(5, 7, 2);
        step(4, 2, "R5 final value");
        @(period_start);
        n_chk++;
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL R2 periods missing: actual %0d left expected 0", exp_q.size());
        end
        finish_run();
    end
endmodule